// File: doc/BRIEF.md
# Line Clock Recovery DPLL

This block rebuilds a bit clock and retimed bipolar data from the sliced pulse indications of a primary-rate line. It runs on a reference clock at twelve times the line rate: 18.528 MHz for T1 (1.544 Mb/s) or 24.576 MHz for E1 (2.048 Mb/s). Each recovered bit window lasts 11, 12 or 13 reference cycles. The count is picked at the end of every window from where the first pulse edge fell inside it. The recovered clock therefore steps toward the incoming phase by one reference cycle per bit and follows line jitter.

The inputs `pos_pulse` and `neg_pulse` are the slicer outputs, synchronous to `clk`. At every rising edge of `rclk_o` the rail outputs present the bit decided in the window that just closed, and `bit_valid_o` strobes for that one reference cycle. The recovered stream has a valid strobe but no ready. A line cannot be stalled, so there is no back-pressure: a consumer must take each bit in the cycle where `bit_valid_o` is high. `lock_o` reports whether the loop is tracking a clean signal. The analog front end, the slicers and the reference oscillator are outside the block.

Top module: `lcr_dpll_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `rclk_o` is 1, and `rpos_o`, `rneg_o`, `bit_valid_o` and `lock_o` are 0.
- R2: A window that contains no pulse edge is followed by a 12-cycle window. The reference-cycle index inside a window counts from 0. `rclk_o` is high while the index is 0 to 5 and low from index 6 to the end of the window.
- R3: Suppose the first rising edge of (`pos_pulse` OR `neg_pulse`) in a window is sampled at index 0 to 4. That edge is early, and the following window lasts 11 cycles.
- R4: A first edge sampled at index 8 or later is late, and the following window lasts 13 cycles.
- R5: A first edge sampled at index 5, 6 or 7 is centred, and the following window lasts 12 cycles.
- R6: A rail output is driven to 1 at the start of the next window when its pulse input was high in any cycle of the current window. It is driven to 0 when the pulse input was low throughout. Rail outputs change only in cycles where `bit_valid_o` is high.
- R7: `lock_o` rises at the end of the 32nd window with a centred edge, counted since the last off-centre edge, carrier loss or restart. Windows with no edge neither add to this count nor clear it. `lock_o` only rises in a cycle where `bit_valid_o` is high.
- R8: Once locked, `lock_o` falls at the end of the 8th consecutive window whose edge is early or late. A centred edge clears this count, and edgeless windows leave it unchanged.
- R9: While `carrier_loss` is high, `lock_o` is 0 in the same cycle, and both lock counts return to zero.
- R10: A change of `rate_sel` (0 = T1, 1 = E1) is taken at the next clock edge and restarts the loop. After that edge, `rclk_o` is 1 and `lock_o` is 0, and the next `bit_valid_o` comes 12 cycles later.
- R11: `bit_valid_o` is high for exactly one cycle per window. It is high only in the cycle where `rclk_o` has just risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 12 times the line rate |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 1 | Line rate: 0 = T1, 1 = E1; a change restarts the loop |
| carrier_loss | input | 1 | High when the line carrier is absent |
| pos_pulse | input | 1 | Positive-rail slicer output |
| neg_pulse | input | 1 | Negative-rail slicer output |
| rclk_o | output | 1 | Recovered bit clock |
| rpos_o | output | 1 | Retimed positive-rail bit |
| rneg_o | output | 1 | Retimed negative-rail bit |
| bit_valid_o | output | 1 | One-cycle strobe when a new bit is presented |
| lock_o | output | 1 | Loop locked and output data valid |

## Verification
A wrong phase counter or divide ratio shows up on `rclk_o` within one bit window, as a rising edge that comes one cycle early or late compared with an independent window model. A lost or stale edge capture gives the wrong ratio in the next window and the wrong rail value at the next `bit_valid_o`. A faulty lock count only becomes visible when `lock_o` changes. The bench therefore runs exact-length sequences of centred and off-centre windows and checks that lock changes in precisely the 32nd or 8th window.

// File: rtl/lcr_pkg.sv
package lcr_pkg;
  // Classification of the first pulse edge seen in a bit window
  typedef enum logic [1:0] {
    EDGE_NONE   = 2'd0,
    EDGE_EARLY  = 2'd1,
    EDGE_CENTRE = 2'd2,
    EDGE_LATE   = 2'd3
  } edge_cls_e;
endpackage

// File: rtl/lcr_divider.sv
module lcr_divider
  import lcr_pkg::*;
#(
  parameter int NOM_DIV = 12,
  parameter int ADJ     = 1,
  parameter int PH_W    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  edge_cls_e       cls,
  output logic [PH_W-1:0] phase,
  output logic            wrap,
  output logic            rclk
);
  localparam int HALF = NOM_DIV / 2;

  logic [PH_W-1:0] phase_q, ratio_q, ratio_nxt, ph_inc;
  logic            rclk_q;

  assign ph_inc = phase_q + PH_W'(1);
  assign wrap   = (phase_q == ratio_q - PH_W'(1));

  // Early edge shortens the next window, late edge lengthens it
  always_comb begin
    case (cls)
      EDGE_EARLY: ratio_nxt = PH_W'(NOM_DIV - ADJ);
      EDGE_LATE:  ratio_nxt = PH_W'(NOM_DIV + ADJ);
      default:    ratio_nxt = PH_W'(NOM_DIV);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      phase_q <= '0;
      ratio_q <= PH_W'(NOM_DIV);
      rclk_q  <= 1'b1;
    end else if (wrap) begin
      phase_q <= '0;
      ratio_q <= ratio_nxt;
      rclk_q  <= 1'b1;
    end else begin
      phase_q <= ph_inc;
      rclk_q  <= (ph_inc < PH_W'(HALF));
    end
  end

  assign phase = phase_q;
  assign rclk  = rclk_q;
endmodule

// File: rtl/lcr_phase_det.sv
module lcr_phase_det
  import lcr_pkg::*;
#(
  parameter int NOM_DIV = 12,
  parameter int TOL     = 1,
  parameter int PH_W    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            pos_in,
  input  logic            neg_in,
  input  logic [PH_W-1:0] phase,
  input  logic            wrap,
  output edge_cls_e       cls,
  output logic            rail_p,
  output logic            rail_n,
  output logic            bit_valid
);
  localparam int HALF = NOM_DIV / 2;
  localparam logic [PH_W-1:0] LO_EDGE = PH_W'(HALF - TOL);
  localparam logic [PH_W-1:0] HI_EDGE = PH_W'(HALF + TOL);

  logic            any_now, any_q, edge_now;
  logic            edge_seen_q;
  logic [PH_W-1:0] edge_ph_q, edge_ph;
  logic            have_edge;
  logic [1:0]      rail_in, seen_q, rail_q;
  logic            valid_q;

  assign any_now   = pos_in | neg_in;
  assign edge_now  = any_now & ~any_q;
  assign have_edge = edge_seen_q | edge_now;
  assign edge_ph   = edge_seen_q ? edge_ph_q : phase;
  assign rail_in   = {neg_in, pos_in};

  always_comb begin
    if (!have_edge)              cls = EDGE_NONE;
    else if (edge_ph < LO_EDGE)  cls = EDGE_EARLY;
    else if (edge_ph > HI_EDGE)  cls = EDGE_LATE;
    else                         cls = EDGE_CENTRE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) any_q <= 1'b0;
    else        any_q <= any_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      edge_seen_q <= 1'b0;
      edge_ph_q   <= '0;
    end else if (wrap) begin
      edge_seen_q <= 1'b0;
    end else if (edge_now && !edge_seen_q) begin
      edge_seen_q <= 1'b1;
      edge_ph_q   <= phase;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) valid_q <= 1'b0;
    else                   valid_q <= wrap;
  end

  // One sticky capture and one retimed output per rail
  for (genvar r = 0; r < 2; r++) begin : g_rail
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seen_q[r] <= 1'b0;
        rail_q[r] <= 1'b0;
      end else if (restart) begin
        seen_q[r] <= 1'b0;
      end else if (wrap) begin
        rail_q[r] <= seen_q[r] | rail_in[r];
        seen_q[r] <= 1'b0;
      end else begin
        seen_q[r] <= seen_q[r] | rail_in[r];
      end
    end
  end

  assign rail_p    = rail_q[0];
  assign rail_n    = rail_q[1];
  assign bit_valid = valid_q;
endmodule

// File: rtl/lcr_lock_mon.sv
module lcr_lock_mon
  import lcr_pkg::*;
#(
  parameter int LOCK_BITS   = 32,
  parameter int UNLOCK_BITS = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      restart,
  input  logic      carrier_loss,
  input  logic      wrap,
  input  edge_cls_e cls,
  output logic      locked
);
  localparam int GW = $clog2(LOCK_BITS + 1);
  localparam int BW = $clog2(UNLOCK_BITS + 1);

  logic [GW-1:0] good_q, good_inc;
  logic [BW-1:0] bad_q, bad_inc;
  logic          locked_q;

  assign good_inc = (good_q == GW'(LOCK_BITS))   ? good_q : good_q + GW'(1);
  assign bad_inc  = (bad_q  == BW'(UNLOCK_BITS)) ? bad_q  : bad_q  + BW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || carrier_loss) begin
      good_q   <= '0;
      bad_q    <= '0;
      locked_q <= 1'b0;
    end else if (wrap) begin
      case (cls)
        EDGE_CENTRE: begin
          good_q <= good_inc;
          bad_q  <= '0;
          if (good_inc == GW'(LOCK_BITS)) locked_q <= 1'b1;
        end
        EDGE_EARLY, EDGE_LATE: begin
          good_q <= '0;
          bad_q  <= bad_inc;
          if (bad_inc == BW'(UNLOCK_BITS)) locked_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign locked = locked_q;
endmodule

// File: rtl/lcr_dpll_top.sv
module lcr_dpll_top
  import lcr_pkg::*;
#(
  parameter int NOM_DIV     = 12,
  parameter int ADJ         = 1,
  parameter int TOL         = 1,
  parameter int LOCK_BITS   = 32,
  parameter int UNLOCK_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_sel,
  input  logic carrier_loss,
  input  logic pos_pulse,
  input  logic neg_pulse,
  output logic rclk_o,
  output logic rpos_o,
  output logic rneg_o,
  output logic bit_valid_o,
  output logic lock_o
);
  localparam int PH_W = $clog2(NOM_DIV + ADJ + 1);

  logic            rate_q, restart, wrap, locked;
  logic [PH_W-1:0] phase;
  edge_cls_e       cls;

  always_ff @(posedge clk) rate_q <= rate_sel;
  assign restart = rst_n && (rate_sel != rate_q);

  lcr_divider #(.NOM_DIV(NOM_DIV), .ADJ(ADJ), .PH_W(PH_W)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(restart), .cls(cls),
    .phase(phase), .wrap(wrap), .rclk(rclk_o)
  );

  lcr_phase_det #(.NOM_DIV(NOM_DIV), .TOL(TOL), .PH_W(PH_W)) u_pd (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .pos_in(pos_pulse), .neg_in(neg_pulse), .phase(phase), .wrap(wrap),
    .cls(cls), .rail_p(rpos_o), .rail_n(rneg_o), .bit_valid(bit_valid_o)
  );

  lcr_lock_mon #(.LOCK_BITS(LOCK_BITS), .UNLOCK_BITS(UNLOCK_BITS)) u_lock (
    .clk(clk), .rst_n(rst_n), .restart(restart), .carrier_loss(carrier_loss),
    .wrap(wrap), .cls(cls), .locked(locked)
  );

  assign lock_o = locked & ~carrier_loss;
endmodule

// File: rtl/lcr_dpll_chk.sv
module lcr_dpll_chk #(
  parameter int NOM_DIV = 12,
  parameter int ADJ     = 1
) (
  input logic clk,
  input logic rst_n,
  input logic rate_sel,
  input logic carrier_loss,
  input logic rclk_o,
  input logic rpos_o,
  input logic rneg_o,
  input logic bit_valid_o,
  input logic lock_o
);
  logic       rate_prev, have_prev;
  logic [7:0] gap;

  always_ff @(posedge clk) begin
    rate_prev <= rate_sel;
    if (!rst_n || rate_sel != rate_prev) begin
      gap       <= '0;
      have_prev <= 1'b0;
    end else if (bit_valid_o) begin
      gap       <= 8'd1;
      have_prev <= 1'b1;
    end else if (gap != 8'hFF) begin
      gap <= gap + 8'd1;
    end
  end

  // R2 R3 R4 R5: window length stays within one step of nominal
  a_r2_period_range: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid_o && have_prev) |-> (gap >= 8'(NOM_DIV - ADJ) && gap <= 8'(NOM_DIV + ADJ)));

  a_r11_valid_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid_o |-> (rclk_o && !$past(rclk_o)));

  a_r6_rails_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid_o |-> ($stable(rpos_o) && $stable(rneg_o)));

  a_r9_carrier_blocks_lock: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_loss |-> !lock_o);

  a_r7_lock_rise_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> bit_valid_o);

  a_r10_rate_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel != rate_prev) |=> (!lock_o && rclk_o));
endmodule

bind lcr_dpll_top lcr_dpll_chk #(.NOM_DIV(NOM_DIV), .ADJ(ADJ)) u_chk (
  .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .carrier_loss(carrier_loss),
  .rclk_o(rclk_o), .rpos_o(rpos_o), .rneg_o(rneg_o),
  .bit_valid_o(bit_valid_o), .lock_o(lock_o)
);

// File: tb/tb_lcr_dpll_top.sv
module tb_lcr_dpll_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_sel = 1'b0;
  logic carrier_loss = 1'b0;
  logic pos_pulse = 1'b0;
  logic neg_pulse = 1'b0;
  logic rclk_o, rpos_o, rneg_o, bit_valid_o, lock_o;

  always #5 clk = ~clk;

  lcr_dpll_top dut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .carrier_loss(carrier_loss),
    .pos_pulse(pos_pulse), .neg_pulse(neg_pulse), .rclk_o(rclk_o),
    .rpos_o(rpos_o), .rneg_o(rneg_o), .bit_valid_o(bit_valid_o), .lock_o(lock_o)
  );

  int checks = 0;
  int fails = 0;
  int last_gap = 0;
  int gap_cnt = 0;
  bit done = 1'b0;

  // Behavioural reference model
  int m_ph, m_div, m_eph, m_good, m_bad;
  bit m_ps, m_ns, m_any, m_rclk, m_rp, m_rn, m_val, m_lock, m_rate;

  always @(posedge clk) begin
    bit anyn, edg;
    int e;
    if (!rst_n) begin
      m_ph = 0; m_div = 12; m_eph = -1; m_ps = 0; m_ns = 0; m_any = 0;
      m_rclk = 1; m_rp = 0; m_rn = 0; m_val = 0; m_good = 0; m_bad = 0;
      m_lock = 0; m_rate = rate_sel;
    end else begin
      anyn = pos_pulse | neg_pulse;
      edg = anyn && !m_any;
      m_any = anyn;
      if (rate_sel != m_rate) begin
        m_rate = rate_sel; m_ph = 0; m_div = 12; m_eph = -1; m_ps = 0; m_ns = 0;
        m_rclk = 1; m_val = 0; m_good = 0; m_bad = 0; m_lock = 0;
      end else begin
        e = (m_eph >= 0) ? m_eph : (edg ? m_ph : -1);
        if (m_ph == m_div - 1) begin
          if (e < 0) m_div = 12;
          else if (e <= 4) m_div = 11;
          else if (e >= 8) m_div = 13;
          else m_div = 12;
          if (e >= 5 && e <= 7) begin
            m_bad = 0;
            if (m_good < 32) m_good++;
            if (m_good == 32) m_lock = 1;
          end else if (e >= 0) begin
            m_good = 0;
            if (m_bad < 8) m_bad++;
            if (m_bad == 8) m_lock = 0;
          end
          m_rp = m_ps | pos_pulse; m_rn = m_ns | neg_pulse;
          m_ps = 0; m_ns = 0; m_eph = -1; m_val = 1; m_rclk = 1; m_ph = 0;
        end else begin
          if (edg && m_eph < 0) m_eph = m_ph;
          m_ps |= pos_pulse; m_ns |= neg_pulse;
          m_ph++; m_val = 0; m_rclk = (m_ph < 6);
        end
        if (carrier_loss) begin m_good = 0; m_bad = 0; m_lock = 0; end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    gap_cnt++;
    if (bit_valid_o) begin last_gap = gap_cnt; gap_cnt = 0; end
    if (rst_n) begin
      chk(rclk_o == m_rclk, "R2", "rclk_o", rclk_o, m_rclk);
      chk(rpos_o == m_rp && rneg_o == m_rn, "R6", "rails",
          {rneg_o, rpos_o}, {m_rn, m_rp});
      chk(bit_valid_o == m_val, "R11", "bit_valid_o", bit_valid_o, m_val);
      chk(lock_o == (m_lock && !carrier_loss), "R7", "lock_o", lock_o,
          m_lock && !carrier_loss);
    end
  endtask

  // off < 0: no pulse; pulse high for three cycles from index off
  task automatic run_window(input int off, input bit on_neg);
    while (m_ph != 0) begin pos_pulse = 0; neg_pulse = 0; tick(); end
    do begin
      bit p;
      p = (off >= 0) && (m_ph >= off) && (m_ph < off + 3);
      pos_pulse = p && !on_neg;
      neg_pulse = p && on_neg;
      tick();
    end while (m_ph != 0);
    pos_pulse = 0; neg_pulse = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) tick();
    chk(rclk_o == 1 && rpos_o == 0 && rneg_o == 0 && bit_valid_o == 0 && lock_o == 0,
        "R1", "reset outputs", {rclk_o, rpos_o, rneg_o, bit_valid_o, lock_o}, 5'b10000);
    rst_n = 1;
    tick();
    chk(rclk_o == 1 && lock_o == 0, "R1", "after release", {rclk_o, lock_o}, 2'b10);

    // R2: free-running windows are 12 cycles
    run_window(-1, 0); run_window(-1, 0);
    chk(last_gap == 12, "R2", "idle window length", last_gap, 12);

    // R3: early edge -> 11
    run_window(2, 0); run_window(-1, 0);
    chk(last_gap == 11, "R3", "window after early edge", last_gap, 11);
    // R4: late edge -> 13
    run_window(9, 0); run_window(-1, 0);
    chk(last_gap == 13, "R4", "window after late edge", last_gap, 13);
    // R5: centred edges at 5 and 7 -> 12
    run_window(5, 0); run_window(-1, 0);
    chk(last_gap == 12, "R5", "window after edge at 5", last_gap, 12);
    run_window(7, 0); run_window(-1, 0);
    chk(last_gap == 12, "R5", "window after edge at 7", last_gap, 12);

    // R6: rail capture
    run_window(6, 0);
    chk(rpos_o == 1 && rneg_o == 0, "R6", "positive bit", {rneg_o, rpos_o}, 2'b01);
    run_window(6, 1);
    chk(rpos_o == 0 && rneg_o == 1, "R6", "negative bit", {rneg_o, rpos_o}, 2'b10);
    run_window(-1, 0);
    chk(rpos_o == 0 && rneg_o == 0, "R6", "zero bit", {rneg_o, rpos_o}, 2'b00);

    // R7: lock after 32 centred, edgeless windows hold the count
    run_window(9, 0);
    for (int i = 0; i < 20; i++) run_window(6, i[0]);
    for (int i = 0; i < 3; i++) run_window(-1, 0);
    for (int i = 0; i < 11; i++) run_window(6, 0);
    chk(lock_o == 0, "R7", "lock after 31 centred", lock_o, 0);
    run_window(6, 0);
    chk(lock_o == 1, "R7", "lock after 32 centred", lock_o, 1);

    // R8: drop after 8 corrected windows
    for (int i = 0; i < 7; i++) run_window(2, 0);
    chk(lock_o == 1, "R8", "lock after 7 early", lock_o, 1);
    run_window(2, 0);
    chk(lock_o == 0, "R8", "lock after 8 early", lock_o, 0);

    // R9: carrier loss
    for (int i = 0; i < 32; i++) run_window(6, 0);
    chk(lock_o == 1, "R9", "relocked", lock_o, 1);
    carrier_loss = 1;
    tick();
    chk(lock_o == 0, "R9", "lock during carrier loss", lock_o, 0);
    carrier_loss = 0;
    run_window(6, 0);
    chk(lock_o == 0, "R9", "count restarted", lock_o, 0);

    // R10: rate change restarts
    for (int i = 0; i < 32; i++) run_window(6, 0);
    tick(); tick(); tick();
    rate_sel = 1;
    tick();
    chk(rclk_o == 1 && lock_o == 0, "R10", "restart state", {rclk_o, lock_o}, 2'b10);
    n = 0;
    do begin tick(); n++; end while (!bit_valid_o && n < 40);
    chk(n == 12, "R10", "first window after restart", n, 12);
    run_window(-1, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule